// File: doc/BRIEF.md
# Pass-Through Write Presentation Port

This block sits on the bridge side of a passive add-on interface. It holds one host write that is waiting for the add-on: the captured address, one data word, the byte enables and the number of the pass-through region that was hit. While that write is pending it drives an active-low attention output and a set of status outputs. The status outputs are a burst indicator, the region number, a write flag and a mask of the bytes that are still valid. The status outputs are meaningful only while attention is asserted.

The add-on logic fetches the pending access through a shared DQ bus. An active-low address-request input puts the stored address on DQ in the same cycle. A register read with read and select both low, the data-register word offset and at least one byte enable active returns the stored word on DQ in the following cycle. Each data read clears the mask bits of the bytes it consumed. The add-on retires the access by pulling ready low. Attention drops in that same cycle, and a new access can be loaded on the next clock.

The host side of the bridge loads a write through a simple valid/ready pair. The load is taken only while no access is pending. DQ is modelled as a driven value plus an output enable, so that the pad can be tristated at the chip level.

Top module: `ptw_port`

## Requirements
- R1: A synchronous active-low reset, sampled on the rising clock edge, clears the pending access. From the next cycle on, `att_n` is 1, `ld_rdy` is 1 and `is_wr` is 0. With `ar_req_n` high, `dq_oe` is 0.
- R2: A load with `ld_valid`=1 and `ld_rdy`=1 is taken at the clock edge. From the next cycle, `att_n`=0, `ld_rdy`=0, `rgn` equals the loaded region, `is_wr`=1, `brst_n`=1 (single data phase) and `bvalid` equals the loaded byte enables (bit i high means byte i is valid).
- R3: While `ar_req_n`=0, `dq_oe`=1 and `dq_o` equals the stored address in the same cycle, with no clock delay.
- R4: When `rd_n`=0, `sel_n`=0, `adr`=5'h0B (byte offset 2Ch) and `be_n` is not all ones in cycle N, then in cycle N+1 `dq_oe`=1 and `dq_o` equals the stored data word, provided `ar_req_n` is high in cycle N+1.
- R5: A data read as in R4, made while an access is pending, clears from the next cycle every `bvalid` bit whose `be_n` bit was 0, so the mask shows the unread bytes. Mask bits are never set while an access stays pending.
- R6: In a cycle where an access is pending and `ack_n`=0, `att_n` is 1 in that same cycle. On the next cycle `ld_rdy`=1 and a new load can be taken.
- R7: In any cycle where `ar_req_n` is high and the previous cycle did not have `rd_n` and `sel_n` both low, `dq_oe`=0.
- R8: If `ar_req_n`=0 in a cycle where a data-register read from the previous cycle would also drive DQ, `dq_o` carries the address.
- R9: A load presented while an access is pending is ignored. The stored address, data, region and mask stay unchanged.
- R10: A read with `rd_n` and `sel_n` low at any offset other than the data register drives `dq_o`=0 with `dq_oe`=1 in the next cycle, and leaves `bvalid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Add-on clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Host side offers a write to present |
| ld_addr | input | DQ_W | Address of the offered write |
| ld_data | input | DQ_W | Data word of the offered write |
| ld_be | input | DQ_W/8 | Byte enables of the offered write, active high |
| ld_rgn | input | $clog2(NUM_RGN) | Pass-through region hit by the write |
| ld_rdy | output | 1 | High while no access is pending |
| ar_req_n | input | 1 | Active-low request to return the address on DQ |
| rd_n | input | 1 | Active-low register read strobe |
| sel_n | input | 1 | Active-low register select |
| adr | input | OFS_W | Register word offset |
| be_n | input | DQ_W/8 | Active-low byte enables of the register read |
| ack_n | input | 1 | Active-low ready from the add-on; retires the access |
| att_n | output | 1 | Active-low attention: an access is pending |
| brst_n | output | 1 | Active-low burst indicator, high for single-phase access |
| rgn | output | $clog2(NUM_RGN) | Region number of the pending access |
| is_wr | output | 1 | Pending access is a write |
| bvalid | output | DQ_W/8 | Bytes of the pending word not yet read |
| dq_o | output | DQ_W | Value driven on the shared DQ bus |
| dq_oe | output | 1 | DQ output enable |

## Verification
A pending flag that is stuck or wrongly set shows up at once on `att_n` and `ld_rdy`. It also shows when a second load is either refused or overwrites the held address, which an address request reveals on DQ in the same cycle. A read strobe register that is wrong shows on `dq_oe` and `dq_o` one cycle after the read strobe. A mask lane that is wrong shows on `bvalid` in the cycle after a data read. Each access in the bench is therefore checked at the address request, one cycle after the data read, and in the retire cycle and the cycle after it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   // Source currently placed on the DQ bus
   typedef enum logic [1:0] {
      DQ_SRC_NONE = 2'd0,
      DQ_SRC_ADDR = 2'd1,
      DQ_SRC_DATA = 2'd2,
      DQ_SRC_ZERO = 2'd3
   } dq_src_e;

   function automatic int unsigned lanes_of(input int unsigned width);
      return width / 8;
   endfunction
endpackage

// File: rtl/ptw_hold.sv
// Holding registers for the one pending access plus its pending flag.
module ptw_hold #(
   parameter int DQ_W  = 32,
   parameter int RGN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             retire,
   input  logic [DQ_W-1:0]  ld_addr,
   input  logic [DQ_W-1:0]  ld_data,
   input  logic [RGN_W-1:0] ld_rgn,
   output logic             pend,
   output logic [DQ_W-1:0]  addr_q,
   output logic [DQ_W-1:0]  data_q,
   output logic [RGN_W-1:0] rgn_q,
   output logic             wr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         wr_q <= 1'b0;
      end else if (take) begin
         pend <= 1'b1;
         wr_q <= 1'b1;
      end else if (retire) begin
         pend <= 1'b0;
      end
   end

   // Payload registers need no reset: only meaningful while pend is set
   always_ff @(posedge clk) begin
      if (take) begin
         addr_q <= ld_addr;
         data_q <= ld_data;
         rgn_q  <= ld_rgn;
      end
   end
endmodule

// File: rtl/ptw_mask.sv
// Byte-valid mask, one generated lane per byte of the data word.
module ptw_mask #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [LANES-1:0] ld_be,
   input  logic             consume,
   input  logic [LANES-1:0] rd_be_n,
   output logic [LANES-1:0] mask
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask[g] <= 1'b0;
         end else if (take) begin
            mask[g] <= ld_be[g];
         end else if (consume && !rd_be_n[g]) begin
            mask[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ptw_rdpath.sv
// Read path onto the DQ bus: same-cycle address, next-cycle register data.
module ptw_rdpath
   import ptw_pkg::*;
#(
   parameter int               DQ_W     = 32,
   parameter int               OFS_W    = 5,
   parameter logic [OFS_W-1:0] DATA_OFS = 5'h0B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ar_req_n,
   input  logic              rd_n,
   input  logic              sel_n,
   input  logic [OFS_W-1:0]  adr,
   input  logic [DQ_W/8-1:0] be_n,
   input  logic [DQ_W-1:0]   addr_q,
   input  logic [DQ_W-1:0]   data_q,
   output logic              data_hit,
   output logic [DQ_W-1:0]   dq_o,
   output logic              dq_oe
);
   localparam int LANES = DQ_W / 8;

   logic    strobe;
   logic    strobe_q;
   logic    hit_q;
   dq_src_e src;

   assign strobe   = !rd_n && !sel_n;
   assign data_hit = strobe && (adr == DATA_OFS) && (be_n != {LANES{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         hit_q    <= 1'b0;
      end else begin
         strobe_q <= strobe;
         hit_q    <= data_hit;
      end
   end

   // Address request wins over a read that matured this cycle
   always_comb begin
      if (!ar_req_n)     src = DQ_SRC_ADDR;
      else if (hit_q)    src = DQ_SRC_DATA;
      else if (strobe_q) src = DQ_SRC_ZERO;
      else               src = DQ_SRC_NONE;
   end

   always_comb begin
      unique case (src)
         DQ_SRC_ADDR: dq_o = addr_q;
         DQ_SRC_DATA: dq_o = data_q;
         default:     dq_o = '0;
      endcase
   end

   assign dq_oe = (src != DQ_SRC_NONE);
endmodule

// File: rtl/ptw_port.sv
// Top: presents one pending host write to a passive add-on bus.
module ptw_port #(
   parameter int                DQ_W     = 32,
   parameter int                NUM_RGN  = 4,
   parameter int                OFS_W    = 5,
   parameter logic [OFS_W-1:0]  DATA_OFS = 5'h0B
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_valid,
   input  logic [DQ_W-1:0]            ld_addr,
   input  logic [DQ_W-1:0]            ld_data,
   input  logic [DQ_W/8-1:0]          ld_be,
   input  logic [$clog2(NUM_RGN)-1:0] ld_rgn,
   output logic                       ld_rdy,
   input  logic                       ar_req_n,
   input  logic                       rd_n,
   input  logic                       sel_n,
   input  logic [OFS_W-1:0]           adr,
   input  logic [DQ_W/8-1:0]          be_n,
   input  logic                       ack_n,
   output logic                       att_n,
   output logic                       brst_n,
   output logic [$clog2(NUM_RGN)-1:0] rgn,
   output logic                       is_wr,
   output logic [DQ_W/8-1:0]          bvalid,
   output logic [DQ_W-1:0]            dq_o,
   output logic                       dq_oe
);
   localparam int LANES = ptw_pkg::lanes_of(DQ_W);
   localparam int RGN_W = $clog2(NUM_RGN);

   // Elaboration-time parameter checks
   if (DQ_W % 8 != 0 || DQ_W < 8) begin : g_bad_width
      $error("ptw_port: DQ_W must be a positive multiple of 8");
   end
   if (NUM_RGN < 2) begin : g_bad_rgn
      $error("ptw_port: NUM_RGN must be at least 2");
   end
   if (OFS_W < 1) begin : g_bad_ofs
      $error("ptw_port: OFS_W must be at least 1");
   end

   logic              pend;
   logic              take;
   logic              retire;
   logic              data_hit;
   logic [DQ_W-1:0]   w_addr;
   logic [DQ_W-1:0]   w_data;
   logic [RGN_W-1:0]  w_rgn;
   logic              w_wr;

   assign take   = ld_valid && !pend;
   assign retire = pend && !ack_n;

   ptw_hold #(
      .DQ_W  (DQ_W),
      .RGN_W (RGN_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .retire  (retire),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .ld_rgn  (ld_rgn),
      .pend    (pend),
      .addr_q  (w_addr),
      .data_q  (w_data),
      .rgn_q   (w_rgn),
      .wr_q    (w_wr)
   );

   ptw_mask #(
      .LANES (LANES)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .ld_be   (ld_be),
      .consume (data_hit && pend),
      .rd_be_n (be_n),
      .mask    (bvalid)
   );

   ptw_rdpath #(
      .DQ_W     (DQ_W),
      .OFS_W    (OFS_W),
      .DATA_OFS (DATA_OFS)
   ) u_rdpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .ar_req_n (ar_req_n),
      .rd_n     (rd_n),
      .sel_n    (sel_n),
      .adr      (adr),
      .be_n     (be_n),
      .addr_q   (w_addr),
      .data_q   (w_data),
      .data_hit (data_hit),
      .dq_o     (dq_o),
      .dq_oe    (dq_oe)
   );

   // Attention falls in the very cycle ready is seen
   assign att_n  = !(pend && ack_n);
   assign ld_rdy = !pend;
   assign brst_n = 1'b1;
   assign rgn    = w_rgn;
   assign is_wr  = w_wr;
endmodule

// File: rtl/ptw_port_chk.sv
module ptw_port_chk #(
   parameter int               DQ_W     = 32,
   parameter int               RGN_W    = 2,
   parameter int               OFS_W    = 5,
   parameter logic [OFS_W-1:0] DATA_OFS = 5'h0B
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic              ld_rdy,
   input logic [RGN_W-1:0]  ld_rgn,
   input logic              ar_req_n,
   input logic              rd_n,
   input logic              sel_n,
   input logic [OFS_W-1:0]  adr,
   input logic [DQ_W/8-1:0] be_n,
   input logic              ack_n,
   input logic              att_n,
   input logic [RGN_W-1:0]  rgn,
   input logic              is_wr,
   input logic [DQ_W/8-1:0] bvalid,
   input logic [DQ_W-1:0]   dq_o,
   input logic              dq_oe,
   input logic [DQ_W-1:0]   addr_q,
   input logic [DQ_W-1:0]   data_q
);
   logic rd_data_now;
   assign rd_data_now = !rd_n && !sel_n && (adr == DATA_OFS) && (be_n != '1);

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (att_n && ld_rdy && !is_wr)); // R1
   AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_rdy) |=> (!ld_rdy && is_wr && rgn == $past(ld_rgn))); // R2
   AST_ADDR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ar_req_n |-> (dq_oe && dq_o == addr_q)); // R3
   AST_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_now && !(ld_valid && ld_rdy)) |=>
         (!ar_req_n || (dq_oe && dq_o == $past(data_q)))); // R4
   AST_MASK_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_rdy && $past(!ld_rdy)) |-> ((bvalid & ~$past(bvalid)) == '0)); // R5
   AST_ACK_DROPS_ATT: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> att_n); // R6
   AST_DQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_req_n && !$past(!rd_n && !sel_n)) |-> !dq_oe); // R7
   AST_ADDR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_data_now) && !ar_req_n) |-> (dq_o == addr_q)); // R8
endmodule

bind ptw_port ptw_port_chk #(
   .DQ_W     (DQ_W),
   .RGN_W    ($clog2(NUM_RGN)),
   .OFS_W    (OFS_W),
   .DATA_OFS (DATA_OFS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_valid (ld_valid),
   .ld_rdy   (ld_rdy),
   .ld_rgn   (ld_rgn),
   .ar_req_n (ar_req_n),
   .rd_n     (rd_n),
   .sel_n    (sel_n),
   .adr      (adr),
   .be_n     (be_n),
   .ack_n    (ack_n),
   .att_n    (att_n),
   .rgn      (rgn),
   .is_wr    (is_wr),
   .bvalid   (bvalid),
   .dq_o     (dq_o),
   .dq_oe    (dq_oe),
   .addr_q   (w_addr),
   .data_q   (w_data)
);

// File: tb/ptw_port_bench.sv
module ptw_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [31:0] ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [3:0]  ld_be = '0;
   logic [1:0]  ld_rgn = '0;
   logic        ld_rdy;
   logic        ar_req_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        sel_n = 1'b1;
   logic [4:0]  adr = '0;
   logic [3:0]  be_n = 4'hF;
   logic        ack_n = 1'b1;
   logic        att_n, brst_n, is_wr, dq_oe;
   logic [1:0]  rgn;
   logic [3:0]  bvalid;
   logic [31:0] dq_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   ptw_port u_ptw_port (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .ld_data(ld_data), .ld_be(ld_be), .ld_rgn(ld_rgn), .ld_rdy(ld_rdy),
      .ar_req_n(ar_req_n), .rd_n(rd_n), .sel_n(sel_n), .adr(adr),
      .be_n(be_n), .ack_n(ack_n), .att_n(att_n), .brst_n(brst_n),
      .rgn(rgn), .is_wr(is_wr), .bvalid(bvalid), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   // {addr, data, be, region, read be_n}
   localparam logic [73:0] VEC [4] = '{
      {32'h0000_1F40, 32'hDEAD_BEEF, 4'hF, 2'd1, 4'h0},
      {32'h8000_0004, 32'h1234_5678, 4'hF, 2'd0, 4'hC},
      {32'h4000_0100, 32'hA5A5_0F0F, 4'h6, 2'd2, 4'hB},
      {32'hFFFF_FFFC, 32'h0000_0001, 4'h9, 2'd3, 4'h7}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] b, input logic [1:0] r);
      ld_valid = 1'b1; ld_addr = a; ld_data = d; ld_be = b; ld_rgn = r;
      tick();
      ld_valid = 1'b0;
   endtask

   task automatic addr_read(input logic [31:0] exp, input string req);
      ar_req_n = 1'b0;
      #1;
      chk(dq_oe == 1'b1 && dq_o == exp, req, dq_o, exp);
      ar_req_n = 1'b1;
      #1;
   endtask

   task automatic reg_read(input logic [4:0] a, input logic [3:0] bn);
      rd_n = 1'b0; sel_n = 1'b0; adr = a; be_n = bn;
      tick();
      rd_n = 1'b1; sel_n = 1'b1; be_n = 4'hF;
      #1;
   endtask

   task automatic retire();
      ack_n = 1'b0;
      #1;
      chk(att_n == 1'b1, "R6 att_n in ready cycle", {31'd0, att_n}, 32'd1);
      tick();
      ack_n = 1'b1;
      #1;
      chk(ld_rdy == 1'b1, "R6 ld_rdy after retire", {31'd0, ld_rdy}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick();
      tick();
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(att_n && ld_rdy && !is_wr && !dq_oe, "R1 reset idle",
          {28'd0, att_n, ld_rdy, is_wr, dq_oe}, 32'hC);

      // Table walk: one access per vector
      foreach (VEC[i]) begin
         logic [31:0] a, d;
         logic [3:0]  b, rb;
         logic [1:0]  r;
         {a, d, b, r, rb} = VEC[i];
         load(a, d, b, r);
         #1;
         chk(!att_n && !ld_rdy && is_wr && brst_n, "R2 status",
             {28'd0, att_n, ld_rdy, is_wr, brst_n}, 32'h3);
         chk(rgn == r, "R2 region", {30'd0, rgn}, {30'd0, r});
         chk(bvalid == b, "R2 byte mask", {28'd0, bvalid}, {28'd0, b});
         addr_read(a, "R3 address same cycle");
         // R7: strobes now asserted, previous cycle had none
         rd_n = 1'b0; sel_n = 1'b0; adr = 5'h0B; be_n = rb;
         #1;
         chk(!dq_oe, "R7 no drive before delay", {31'd0, dq_oe}, 32'd0);
         tick();
         rd_n = 1'b1; sel_n = 1'b1; be_n = 4'hF;
         #1;
         chk(dq_oe && dq_o == d, "R4 data next cycle", dq_o, d);
         chk(bvalid == (b & rb), "R5 mask after read", {28'd0, bvalid},
             {28'd0, b & rb});
         tick();
         chk(!dq_oe, "R7 release", {31'd0, dq_oe}, 32'd0);
         retire();
      end

      // R9: load ignored while pending
      load(32'h0000_0AA0, 32'hCAFE_0001, 4'h3, 2'd2);
      load(32'h0000_0BB0, 32'hCAFE_0002, 4'hC, 2'd1);
      #1;
      chk(rgn == 2'd2 && bvalid == 4'h3, "R9 status kept",
          {26'd0, rgn, bvalid}, {26'd0, 2'd2, 4'h3});
      addr_read(32'h0000_0AA0, "R9 address kept");

      // R10: other offset returns zero and leaves mask
      reg_read(5'h05, 4'h0);
      chk(dq_oe && dq_o == 32'd0, "R10 other offset zero", dq_o, 32'd0);
      chk(bvalid == 4'h3, "R10 mask unchanged", {28'd0, bvalid}, 32'h3);

      // R8: address request in the data-return cycle
      rd_n = 1'b0; sel_n = 1'b0; adr = 5'h0B; be_n = 4'hE;
      tick();
      rd_n = 1'b1; sel_n = 1'b1; be_n = 4'hF;
      ar_req_n = 1'b0;
      #1;
      chk(dq_oe && dq_o == 32'h0000_0AA0, "R8 address wins", dq_o, 32'h0000_0AA0);
      ar_req_n = 1'b1;
      #1;
      chk(dq_o == 32'hCAFE_0001, "R4 data after priority release", dq_o,
          32'hCAFE_0001);
      chk(bvalid == 4'h2, "R5 partial consume", {28'd0, bvalid}, 32'h2);

      // R6: new load accepted on the clock after retire
      retire();
      load(32'h0000_0CC0, 32'h7777_8888, 4'hF, 2'd3);
      #1;
      chk(!att_n && rgn == 2'd3, "R6 back-to-back load", {29'd0, att_n, rgn},
          {29'd0, 1'b0, 2'd3});

      // R1: reset in the middle of an access
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      #1;
      chk(att_n && ld_rdy && !is_wr, "R1 reset mid access",
          {29'd0, att_n, ld_rdy, is_wr}, 32'h6);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule